// File: doc/BRIEF.md
# Break-Protected Two-Step Status Flag

This block holds a bank of status flags. Each flag is set by a hardware event and cleared by software in two steps. In the first step, software reads the status register while the flag is 1, which arms the flag. In the second step, a later access to the paired data register clears the flag. A shared clear-enable bit works together with a debug-halt input to decide whether clearing may happen while the system is stopped for debug. When clearing is not enabled, a debugger can read and write every register without losing any status.

The debug-halt state is called "protected" when the halt input is high and the clear-enable bit is 0. In that state the flags and their armed state are frozen against all software accesses; only a new hardware event can still set a flag. A flag armed before the halt keeps its armed state through it, so one data access after the halt finishes the clear. Bus decode and halt detection sit outside the block; they drive the per-flag access strobes and the halt input.

Top module: `flagbrk`

## Requirements
- R1: Reset (rst_ni low) drives every flag_o bit to 0, clears every armed state and drives clr_en_o to 0.
- R2: A set_i[k] pulse makes flag_o[k] read 1 from the next cycle.
- R3: When rd_stat_i[k] is pulsed while flag_o[k] is 1 and clearing is allowed, flag k becomes armed. A later acc_data_i[k] pulse clears flag_o[k] on the following cycle.
- R4: An acc_data_i[k] pulse on a flag that is not armed leaves flag_o[k] unchanged.
- R5: When brk_i is 1 and clr_en_o is 0, rd_stat_i does not arm a flag. In the same state, acc_data_i neither clears a flag nor consumes its armed state.
- R6: A flag armed before a protected halt stays armed through it. The first acc_data_i pulse after brk_i returns to 0 clears the flag.
- R7: When clr_en_o is 1, the two-step clear also works while brk_i is 1.
- R8: A flag cleared during a halt stays 0 after brk_i returns to 0.
- R9: A set_i pulse on an armed flag keeps the flag at 1 and removes the armed state, so a fresh rd_stat_i is needed before an acc_data_i can clear it.
- R10: A set_i pulse wins over a clearing acc_data_i that arrives in the same cycle.
- R11: A clr_en_we_i pulse loads clr_en_wd_i into clr_en_o, which shows the new value from the next cycle.
- R12: A rd_stat_i and an acc_data_i in the same cycle on a set flag that is not armed only arm it; the flag stays 1.
- R13: Every flag lane reacts only to its own set_i, rd_stat_i and acc_data_i bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| set_i | input | N | Per-flag hardware set event |
| rd_stat_i | input | N | Per-flag status-read strobe (step one) |
| acc_data_i | input | N | Per-flag data-register access strobe (step two) |
| brk_i | input | 1 | Debug halt active |
| clr_en_we_i | input | 1 | Write strobe for the clear-enable bit |
| clr_en_wd_i | input | 1 | Value written to the clear-enable bit |
| clr_en_o | output | 1 | Current clear-enable bit |
| flag_o | output | N | Status flags |

## Verification
The bench targets four kinds of error:
- An armed state that a protected halt loses or consumes. A design with this error would leave the flag set after the post-halt data access.
- An arm taken during a protected halt. A design with this error would clear the flag on the first access after the halt.
- A set event that does not drop the armed state, or that loses to a same-cycle clear. A design with this error would show 0 where 1 is expected.
- A flag that reappears after the halt ends, and a combined read-and-access cycle that clears the flag in one step.

// File: rtl/flagbrk_pkg.sv
package flagbrk_pkg;
  typedef struct packed {
    logic set;
    logic rd;
    logic acc;
  } flag_evt_t;
endpackage

// File: rtl/flagbrk_clr_en.sv
module flagbrk_clr_en (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic wd_i,
  input  logic brk_i,
  output logic en_o,
  output logic clr_ok_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= 1'b0;
    else if (we_i) en_q <= wd_i;
  end

  assign en_o     = en_q;
  assign clr_ok_o = !brk_i || en_q;
endmodule

// File: rtl/flagbrk_cell.sv
module flagbrk_cell
  import flagbrk_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  flag_evt_t evt_i,
  input  logic      clr_ok_i,
  output logic      flag_o,
  output logic      armed_o
);
  logic flag_q, armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (evt_i.set) begin
      flag_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (clr_ok_i) begin
      if (armed_q && evt_i.acc) begin
        flag_q  <= 1'b0;
        armed_q <= 1'b0;
      end else if (flag_q && evt_i.rd) begin
        armed_q <= 1'b1;
      end
    end
  end

  assign flag_o  = flag_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/flagbrk.sv
module flagbrk
  import flagbrk_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] rd_stat_i,
  input  logic [N-1:0] acc_data_i,
  input  logic         brk_i,
  input  logic         clr_en_we_i,
  input  logic         clr_en_wd_i,
  output logic         clr_en_o,
  output logic [N-1:0] flag_o
);
  logic         clr_ok;
  logic [N-1:0] armed;

  flagbrk_clr_en u_clr_en (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (clr_en_we_i),
    .wd_i     (clr_en_wd_i),
    .brk_i    (brk_i),
    .en_o     (clr_en_o),
    .clr_ok_o (clr_ok)
  );

  for (genvar k = 0; k < N; k++) begin : g_lane
    flag_evt_t evt;
    assign evt = '{set: set_i[k], rd: rd_stat_i[k], acc: acc_data_i[k]};

    flagbrk_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (evt),
      .clr_ok_i (clr_ok),
      .flag_o   (flag_o[k]),
      .armed_o  (armed[k])
    );
  end
endmodule

// File: rtl/flagbrk_chk.sv
module flagbrk_chk #(
  parameter int N = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] set_i,
  input logic [N-1:0] acc_data_i,
  input logic         brk_i,
  input logic         clr_en_we_i,
  input logic         clr_en_wd_i,
  input logic         clr_en_o,
  input logic [N-1:0] flag_o,
  input logic [N-1:0] armed
);
  a_r11_en_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_we_i |=> clr_en_o == $past(clr_en_wd_i));

  for (genvar k = 0; k < N; k++) begin : g_chk
    a_r2_set_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> flag_o[k]);

    a_r9_set_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> !armed[k]);

    a_r5_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (brk_i && !clr_en_o && !set_i[k]) |=>
        (flag_o[k] == $past(flag_o[k])) && (armed[k] == $past(armed[k])));

    a_r3_clear_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flag_o[k]) |-> ($past(acc_data_i[k]) && $past(armed[k])));

    a_r4_armed_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed[k] |-> flag_o[k]);
  end
endmodule

bind flagbrk flagbrk_chk #(.N(N)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .set_i       (set_i),
  .acc_data_i  (acc_data_i),
  .brk_i       (brk_i),
  .clr_en_we_i (clr_en_we_i),
  .clr_en_wd_i (clr_en_wd_i),
  .clr_en_o    (clr_en_o),
  .flag_o      (flag_o),
  .armed       (armed)
);

// File: tb/flagbrk_bench.sv
module flagbrk_bench;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] set_v = '0, rd_v = '0, acc_v = '0;
  logic         brk = 1'b0, we = 1'b0, wd = 1'b0;
  logic         clr_en;
  logic [N-1:0] flag;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;

  bit  m_flag [N];
  bit  m_arm  [N];
  bit  m_en;

  always #10 clk = ~clk;

  flagbrk #(.N(N)) u_flagbrk (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .set_i       (set_v),
    .rd_stat_i   (rd_v),
    .acc_data_i  (acc_v),
    .brk_i       (brk),
    .clr_en_we_i (we),
    .clr_en_wd_i (wd),
    .clr_en_o    (clr_en),
    .flag_o      (flag)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0;
      for (int k = 0; k < N; k++) begin m_flag[k] = 0; m_arm[k] = 0; end
    end else begin
      bit ok;
      ok = !brk || m_en;
      for (int k = 0; k < N; k++) begin
        if (set_v[k]) begin
          m_flag[k] = 1; m_arm[k] = 0;
        end else if (ok) begin
          if (m_arm[k] && acc_v[k]) begin m_flag[k] = 0; m_arm[k] = 0; end
          else if (m_flag[k] && rd_v[k]) m_arm[k] = 1;
        end
      end
      if (we) m_en = wd;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [N-1:0] mf;
      for (int k = 0; k < N; k++) mf[k] = m_flag[k];
      checks++;
      if (flag !== mf || clr_en !== m_en) begin
        errors++;
        $display("FAIL model: flag=%b en=%b expected flag=%b en=%b", flag, clr_en, mf, m_en);
      end
    end
  end

  task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // apply strobes for one edge, then return at the following negedge
  task automatic cyc(input logic [N-1:0] s, input logic [N-1:0] r, input logic [N-1:0] a);
    set_v = s; rd_v = r; acc_v = a;
    @(posedge clk);
    @(negedge clk);
    set_v = '0; rd_v = '0; acc_v = '0;
  endtask

  task automatic wr_en(input logic v);
    we = 1'b1; wd = v;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0; wd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 flags in reset", flag, 4'b0000);
    chk("R1 enable in reset", {3'b0, clr_en}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);

    cyc(4'b0001, 0, 0);
    chk("R2 set", flag, 4'b0001);
    cyc(0, 0, 4'b0001);
    chk("R4 access unarmed", flag, 4'b0001);
    cyc(0, 4'b0001, 0);
    chk("R3 read keeps flag", flag, 4'b0001);
    cyc(0, 0, 4'b0001);
    chk("R3 clear", flag, 4'b0000);

    cyc(4'b0001, 0, 0);
    cyc(0, 4'b0001, 4'b0001);
    chk("R12 same-cycle arms only", flag, 4'b0001);
    cyc(0, 0, 4'b0001);
    chk("R12 later access clears", flag, 4'b0000);

    // armed before protected halt
    cyc(4'b0001, 0, 0);
    cyc(0, 4'b0001, 0);
    brk = 1'b1;
    cyc(0, 0, 4'b0001);
    chk("R5 access blocked", flag, 4'b0001);
    cyc(0, 4'b0001, 0);
    brk = 1'b0;
    cyc(0, 0, 0);
    cyc(0, 0, 4'b0001);
    chk("R6 armed survives halt", flag, 4'b0000);

    // step one during protected halt does not arm
    cyc(4'b0001, 0, 0);
    brk = 1'b1;
    cyc(0, 4'b0001, 0);
    brk = 1'b0;
    cyc(0, 0, 4'b0001);
    chk("R5 no arm during halt", flag, 4'b0001);
    cyc(0, 4'b0001, 0);
    cyc(0, 0, 4'b0001);
    chk("R3 cleanup", flag, 4'b0000);

    wr_en(1'b1);
    chk("R11 enable on", {3'b0, clr_en}, 4'b0001);

    cyc(4'b0001, 0, 0);
    brk = 1'b1;
    cyc(0, 4'b0001, 0);
    cyc(0, 0, 4'b0001);
    chk("R7 clear in halt when enabled", flag, 4'b0000);
    brk = 1'b0;
    cyc(0, 0, 0);
    chk("R8 stays clear after halt", flag, 4'b0000);

    wr_en(1'b0);
    chk("R11 enable off", {3'b0, clr_en}, 4'b0000);

    cyc(4'b0001, 0, 0);
    cyc(0, 4'b0001, 0);
    cyc(4'b0001, 0, 0);
    cyc(0, 0, 4'b0001);
    chk("R9 set disarms", flag, 4'b0001);
    cyc(0, 4'b0001, 0);
    cyc(0, 0, 4'b0001);
    chk("R9 fresh read clears", flag, 4'b0000);

    cyc(4'b0001, 0, 0);
    cyc(0, 4'b0001, 0);
    cyc(4'b0001, 0, 4'b0001);
    chk("R10 set wins", flag, 4'b0001);
    cyc(0, 0, 4'b0001);
    chk("R10 disarmed after set", flag, 4'b0001);
    cyc(0, 4'b0001, 0);
    cyc(0, 0, 4'b0001);

    cyc(4'b0110, 0, 0);
    chk("R13 two lanes set", flag, 4'b0110);
    cyc(0, 4'b0010, 0);
    cyc(0, 0, 4'b0110);
    chk("R13 only lane 1 clears", flag, 4'b0100);

    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-run", flag, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule